// File: doc/BRIEF.md
# Serial Receive Framer with Trailing-Check Removal

The block sits after a bit decoder and before a receive FIFO. A start pulse opens a frame. The decoder then hands over one bit at a time with a valid strobe, and the block packs those bits into bytes, least significant bit first. When parity is enabled, it also checks a parity bit that follows each byte. A frame closes either on an end-of-frame pulse or when the reported signal strength drops below a programmed 4-bit floor. At that point the block returns to idle and raises a one-cycle interrupt, and the status flags are left for software to read.

A frame may end in a check block of one byte (CRC-8) or two bytes (CRC-16). When checking is enabled, every byte passes through a hold line whose depth equals the check length, so the FIFO sees each byte that many bytes late. On a good check, the bytes still in the hold line are the check block, and they are dropped. On a bad check, they are flushed to the FIFO one per cycle, so software receives everything, including the faulty check bytes. When checking is disabled, bytes go straight to the FIFO port.

Top module: `rx_framer`

## Requirements
- R1: With checking disabled, each completed byte is written once to the FIFO port as a single-cycle `fifo_wr` strobe with `fifo_data`, in arrival order, with bits taken least significant first; `fifo_wr` is never high while `rx_active` is low.
- R2: With parity enabled, the bit after each byte is its parity; `cfg_par_odd`=1 expects the nine bits to hold an odd count of ones, 0 an even count; a mismatch sets the sticky `par_err` and the byte is still delivered.
- R3: With parity disabled, every eight bits form a byte and `par_err` stays low.
- R4: With `cfg_crc_en`=1 and `cfg_crc_one_byte`=0, the last two bytes are a CRC-16 (reflected polynomial 0x8408, preset 0x6363, low byte sent first); when the residue over all bytes is zero, only the bytes before those two reach the FIFO and `crc_err` stays low.
- R5: With `cfg_crc_en`=1 and `cfg_crc_one_byte`=1, the last byte is a CRC-8 (polynomial 0x07, preset 0x00, most significant bit first in the register); when the residue is zero, only the bytes before it reach the FIFO.
- R6: When the residue is non-zero, every received byte including the check bytes reaches the FIFO in order, and the sticky `crc_err` is set.
- R7: An `rx_eof` pulse ends reception; bits of an unfinished byte are discarded; `irq` pulses for exactly one cycle as `rx_active` falls.
- R8: Reception also ends when `sig_level` is below `cfg_min_level`; a floor of 0 never ends it.
- R9: `rx_sof` in idle starts a frame and clears `par_err` and `crc_err`; bits offered while idle produce no FIFO write.
- R10: With checking enabled, a frame with fewer bytes than the check length counts as a failed check: all of its bytes are written and `crc_err` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_crc_en | input | 1 | Enable trailing check, sampled at frame start |
| cfg_crc_one_byte | input | 1 | 1: CRC-8, 0: CRC-16 |
| cfg_par_en | input | 1 | Expect a parity bit after each byte |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_min_level | input | LVL_W | Signal-strength floor |
| sig_level | input | LVL_W | Current signal strength |
| rx_sof | input | 1 | Frame start pulse |
| rx_eof | input | 1 | Frame end pulse |
| bit_vld | input | 1 | Decoded bit is valid |
| bit_val | input | 1 | Decoded bit value |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write byte |
| rx_active | output | 1 | Frame in progress |
| irq | output | 1 | One-cycle end-of-reception pulse |
| par_err | output | 1 | Sticky parity error |
| crc_err | output | 1 | Sticky check error |

## Verification
Frames run under each check mode: off, one byte and two bytes. Some carry a correct check and some a corrupted byte. This separates the drop path, the flush path and the bypass, and shows whether the hold depth follows the mode. Parity runs both odd and even, with and without an injected wrong parity bit, which confirms that the sense of parity is right and that a bad parity bit does not disturb the data. Frames are ended by the end pulse and by a signal drop, some with a trailing partial byte, along with frames shorter than the check block and a floor of zero. Random gaps between bits show that output does not depend on bit timing.

// File: rtl/rx_framer_pkg.sv
// Package: shared types and check-code arithmetic for the receive framer.
// Assumes bytes of eight bits; both check codes are byte-serial.
package rx_framer_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_CHECK = 2'd2,
        ST_FLUSH = 2'd3
    } rx_state_t;

    localparam logic [15:0] CRC16_PRESET = 16'h6363;
    localparam logic [15:0] CRC16_POLY_R = 16'h8408;
    localparam logic [7:0]  CRC8_PRESET  = 8'h00;
    localparam logic [7:0]  CRC8_POLY    = 8'h07;

    // Fold one byte into a reflected 16-bit check register.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC16_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

    // Fold one byte into a forward 8-bit check register.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++) begin
            r = r[7] ? ((r << 1) ^ CRC8_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_bit_packer.sv
// Module: packs serial bits (LSB first) into bytes and checks the
// optional parity bit that follows each byte.
// Assumes: clr and bit_vld are never high together with meaning; clr wins.
module rx_bit_packer
    import rx_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_out,
    output logic              par_bad
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] PAR_SLOT  = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] shreg;

    // Bit counter, shift register, byte strobe and parity comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_out <= '0;
            par_bad  <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            par_bad  <= 1'b0;
            if (clr) begin
                cnt <= '0;
            end else if (bit_vld) begin
                if (cnt == PAR_SLOT) begin
                    par_bad <= (bit_in != ((^byte_out) ^ par_odd));
                    cnt     <= '0;
                end else if (cnt == LAST_DATA) begin
                    byte_vld <= 1'b1;
                    byte_out <= {bit_in, shreg};
                    cnt      <= par_en ? PAR_SLOT : '0;
                end else begin
                    shreg <= {bit_in, shreg[BYTE_W-2:1]};
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rx_crc_unit.sv
// Module: running check register, CRC-8 or reflected CRC-16, with a
// zero-residue flag. Assumes sel is held stable between init and the check.
module rx_crc_unit
    import rx_framer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              upd,
    input  logic              sel8,
    input  logic [BYTE_W-1:0] din,
    output logic              res_zero
);
    logic [15:0] crc_q;

    // Preset on init, fold in each delivered byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC16_PRESET;
        end else if (init) begin
            crc_q <= sel8 ? {8'h00, CRC8_PRESET} : CRC16_PRESET;
        end else if (upd) begin
            crc_q <= sel8 ? {8'h00, crc8_step(crc_q[7:0], din)} : crc16_step(crc_q, din);
        end
    end

    // Residue test for the selected width.
    always_comb begin
        res_zero = sel8 ? (crc_q[7:0] == 8'h00) : (crc_q == 16'h0000);
    end

endmodule

// File: rtl/rx_hold_line.sv
// Module: byte delay line of run-time depth (1..MAX_DEPTH). A push into a
// full line emits the oldest byte; pop drains one byte; clr discards all.
// Assumes depth >= 1 whenever push is used and push/pop are exclusive.
module rx_hold_line #(
    parameter int W         = 8,
    parameter int MAX_DEPTH = 2,
    localparam int CW       = $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] depth,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic          out_vld,
    output logic [W-1:0]  out_data,
    output logic [CW-1:0] cnt
);
    logic [W-1:0] mem [MAX_DEPTH];

    // Fill, shift-through, drain and discard of the held bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
            for (int i = 0; i < MAX_DEPTH; i++) mem[i] <= '0;
        end else begin
            out_vld <= 1'b0;
            if (clr) begin
                cnt <= '0;
            end else if (push) begin
                if (cnt < depth) begin
                    for (int i = 0; i < MAX_DEPTH; i++)
                        if (i == int'(cnt)) mem[i] <= din;
                    cnt <= cnt + 1'b1;
                end else begin
                    out_vld  <= 1'b1;
                    out_data <= mem[0];
                    for (int i = 0; i < MAX_DEPTH - 1; i++)
                        if (i < int'(depth) - 1) mem[i] <= mem[i+1];
                    for (int i = 0; i < MAX_DEPTH; i++)
                        if (i == int'(depth) - 1) mem[i] <= din;
                end
            end else if (pop && cnt != '0) begin
                out_vld  <= 1'b1;
                out_data <= mem[0];
                for (int i = 0; i < MAX_DEPTH - 1; i++) mem[i] <= mem[i+1];
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rx_framer.sv
// Module: receive framer top. Frames serial bits into bytes, checks parity
// and an optional trailing check code, withholds a good check code from the
// FIFO and flushes a bad one. Ends on an end pulse or a signal drop.
// Assumes configuration is stable from rx_sof to the end of the frame; it is
// captured at frame start.
module rx_framer
    import rx_framer_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_crc_en,
    input  logic              cfg_crc_one_byte,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [LVL_W-1:0]  cfg_min_level,
    input  logic [LVL_W-1:0]  sig_level,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              bit_vld,
    input  logic              bit_val,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_data,
    output logic              rx_active,
    output logic              irq,
    output logic              par_err,
    output logic              crc_err
);
    localparam int HOLD_MAX = 2;
    localparam int HOLD_CW  = $clog2(HOLD_MAX + 1);

    rx_state_t         state;
    logic              l_crc_en, l_crc8, l_par_en, l_par_odd;
    logic [LVL_W-1:0]  l_min;
    logic              start, stop_req, take_bit;
    logic              byte_vld, par_bad, res_zero;
    logic [BYTE_W-1:0] byte_out;
    logic [HOLD_CW-1:0] hold_depth, hold_cnt;
    logic              hold_clr, hold_pop, hold_vld;
    logic [BYTE_W-1:0] hold_data;
    logic              byp_vld;
    logic [BYTE_W-1:0] byp_data;
    logic              check_ok;

    // Frame control decode from state and inputs.
    always_comb begin
        start      = (state == ST_IDLE) && rx_sof;
        stop_req   = (state == ST_RECV) && (rx_eof || (sig_level < l_min));
        take_bit   = (state == ST_RECV) && !stop_req && bit_vld;
        hold_depth = l_crc8 ? HOLD_CW'(1) : HOLD_CW'(2);
        check_ok   = res_zero && (hold_cnt == hold_depth);
        hold_clr   = start || ((state == ST_CHECK) && l_crc_en && check_ok);
        hold_pop   = (state == ST_FLUSH) && (hold_cnt != '0);
        rx_active  = (state != ST_IDLE);
    end

    rx_bit_packer u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .bit_vld (take_bit),
        .bit_in  (bit_val),
        .par_en  (l_par_en),
        .par_odd (l_par_odd),
        .byte_vld(byte_vld),
        .byte_out(byte_out),
        .par_bad (par_bad)
    );

    rx_crc_unit u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (start),
        .upd     (byte_vld && l_crc_en),
        .sel8    (start ? cfg_crc_one_byte : l_crc8),
        .din     (byte_out),
        .res_zero(res_zero)
    );

    rx_hold_line #(.W(BYTE_W), .MAX_DEPTH(HOLD_MAX)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hold_clr),
        .depth   (hold_depth),
        .push    (byte_vld && l_crc_en),
        .din     (byte_out),
        .pop     (hold_pop),
        .out_vld (hold_vld),
        .out_data(hold_data),
        .cnt     (hold_cnt)
    );

    // Direct path used when no check code is expected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_vld  <= 1'b0;
            byp_data <= '0;
        end else begin
            byp_vld  <= byte_vld && !l_crc_en;
            byp_data <= byte_out;
        end
    end

    // FIFO port merge of the direct and delayed paths.
    always_comb begin
        fifo_wr   = byp_vld | hold_vld;
        fifo_data = hold_vld ? hold_data : byp_data;
    end

    // Frame state machine, configuration capture, flags and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            l_crc_en  <= 1'b0;
            l_crc8    <= 1'b0;
            l_par_en  <= 1'b0;
            l_par_odd <= 1'b0;
            l_min     <= '0;
            par_err   <= 1'b0;
            crc_err   <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (par_bad) par_err <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (rx_sof) begin
                        l_crc_en  <= cfg_crc_en;
                        l_crc8    <= cfg_crc_one_byte;
                        l_par_en  <= cfg_par_en;
                        l_par_odd <= cfg_par_odd;
                        l_min     <= cfg_min_level;
                        par_err   <= 1'b0;
                        crc_err   <= 1'b0;
                        state     <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (stop_req) state <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (l_crc_en && !check_ok) begin
                        crc_err <= 1'b1;
                        state   <= ST_FLUSH;
                    end else begin
                        irq   <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_FLUSH: begin
                    if (hold_cnt == '0) begin
                        irq   <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_framer_chk.sv
// Checker: temporal properties of the receive framer, bound to the top.
module rx_framer_chk #(
    parameter int HOLD_CW = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_sof,
    input logic               rx_active,
    input logic               irq,
    input logic               fifo_wr,
    input logic               par_err,
    input logic               crc_err,
    input logic               l_crc_en,
    input logic [HOLD_CW-1:0] hold_cnt,
    input logic [HOLD_CW-1:0] hold_depth
);
    AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |-> !fifo_wr);                                           // R1
    AST_BYPASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_crc_en && rx_active) |-> (hold_cnt == '0));                     // R1
    AST_HOLD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |-> (hold_cnt <= hold_depth));                            // R4
    AST_CRC_ERR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> l_crc_en);                                       // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);                                                      // R7
    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_active) |-> irq);                                          // R7
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && !rx_active) |=> (rx_active && !par_err && !crc_err));    // R9
endmodule

bind rx_framer rx_framer_chk #(.HOLD_CW(HOLD_CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_sof    (rx_sof),
    .rx_active (rx_active),
    .irq       (irq),
    .fifo_wr   (fifo_wr),
    .par_err   (par_err),
    .crc_err   (crc_err),
    .l_crc_en  (l_crc_en),
    .hold_cnt  (hold_cnt),
    .hold_depth(hold_depth)
);

// File: tb/rx_framer_tb_top.sv
// Bench: directed and seeded-random frames against a byte-level model.
module rx_framer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_crc_en = 0, cfg_crc_one_byte = 0, cfg_par_en = 0, cfg_par_odd = 0;
    logic [3:0] cfg_min_level = 0, sig_level = 4'hF;
    logic       rx_sof = 0, rx_eof = 0, bit_vld = 0, bit_val = 0;
    logic       fifo_wr, rx_active, irq, par_err, crc_err;
    logic [7:0] fifo_data;

    int n_chk = 0, n_fail = 0, irq_cnt = 0, cyc = 0;
    logic [7:0] got[$];
    logic [7:0] frm[$];
    int  bad_par = -1, extra = 0;
    bit  sig_stop = 0;

    always #2.5 clk = ~clk;

    rx_framer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_crc_en(cfg_crc_en), .cfg_crc_one_byte(cfg_crc_one_byte),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_min_level(cfg_min_level),
        .sig_level(sig_level), .rx_sof(rx_sof), .rx_eof(rx_eof), .bit_vld(bit_vld),
        .bit_val(bit_val), .fifo_wr(fifo_wr), .fifo_data(fifo_data), .rx_active(rx_active),
        .irq(irq), .par_err(par_err), .crc_err(crc_err)
    );

    // Output monitor sampling away from the active edge.
    always @(negedge clk) begin
        if (fifo_wr) got.push_back(fifo_data);
        if (irq) irq_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] m_crc16(input logic [7:0] q[$], input int n);
        logic [15:0] c = 16'h6363;
        for (int i = 0; i < n; i++) begin
            c ^= {8'h00, q[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return c;
    endfunction

    function automatic logic [7:0] m_crc8(input logic [7:0] q[$], input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            c ^= q[i];
            for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    // Append a correct check block for the current mode.
    task automatic add_check();
        logic [15:0] c16;
        if (cfg_crc_one_byte) frm.push_back(m_crc8(frm, frm.size()));
        else begin
            c16 = m_crc16(frm, frm.size());
            frm.push_back(c16[7:0]);
            frm.push_back(c16[15:8]);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_vld = 1'b1; bit_val = b;
        @(negedge clk);
        bit_vld = 1'b0;
        if ($urandom_range(3) == 0) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit flip);
        for (int b = 0; b < 8; b++) send_bit(v[b]);
        if (cfg_par_en) send_bit((^v) ^ cfg_par_odd ^ flip);
    endtask

    // Run one frame from frm and compare against the model.
    task automatic run_frame(input string req);
        logic [7:0] exp_q[$];
        int  depth, w;
        bit  ok;
        got.delete(); irq_cnt = 0;
        @(negedge clk) rx_sof = 1'b1;
        @(negedge clk) rx_sof = 1'b0;
        chk(par_err == 0 && crc_err == 0 && rx_active == 1, {req, " R9 flags clear at start"},
            {par_err, crc_err, rx_active}, 1);
        foreach (frm[i]) send_byte(frm[i], i == bad_par);
        for (int i = 0; i < extra; i++) send_bit($urandom_range(1));
        if (sig_stop) begin
            sig_level = cfg_min_level - 4'd1;
            @(negedge clk) sig_level = 4'hF;
        end else begin
            rx_eof = 1'b1;
            @(negedge clk) rx_eof = 1'b0;
        end
        w = 0;
        while (irq_cnt == 0 && w < 40) begin @(negedge clk); w++; end
        repeat (3) @(negedge clk);
        exp_q = frm;
        ok = 1;
        if (cfg_crc_en) begin
            depth = cfg_crc_one_byte ? 1 : 2;
            ok = (frm.size() >= depth) &&
                 (cfg_crc_one_byte ? (m_crc8(frm, frm.size()) == 0) : (m_crc16(frm, frm.size()) == 0));
            if (ok) for (int i = 0; i < depth; i++) void'(exp_q.pop_back());
        end
        chk(irq_cnt == 1 && !rx_active, {req, " R7 single irq, idle"}, irq_cnt, 1);
        chk(got.size() == exp_q.size(), {req, " byte count"}, got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            chk(got[i] == exp_q[i], {req, " byte value"}, got[i], exp_q[i]);
        chk(crc_err == (cfg_crc_en && !ok), {req, " R6 crc_err"}, crc_err, cfg_crc_en && !ok);
        chk(par_err == (cfg_par_en && bad_par >= 0 && bad_par < frm.size()), {req, " R2 par_err"},
            par_err, cfg_par_en && bad_par >= 0);
    endtask

    task automatic cfg(input bit ce, input bit c8, input bit pe, input bit po);
        cfg_crc_en = ce; cfg_crc_one_byte = c8; cfg_par_en = pe; cfg_par_odd = po;
        bad_par = -1; extra = 0; sig_stop = 0; cfg_min_level = 4'd0;
        frm.delete();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fifo_wr && !rx_active && !irq && !par_err && !crc_err, "reset state",
            {fifo_wr, rx_active, irq, par_err, crc_err}, 0);

        // R9: bits while idle are ignored.
        got.delete();
        for (int i = 0; i < 16; i++) send_bit(i[0]);
        chk(got.size() == 0 && !rx_active, "R9 idle bits ignored", got.size(), 0);

        cfg(0, 0, 0, 0); frm = '{8'hA5, 8'h3C, 8'hFF}; run_frame("R1 R3 bypass");
        cfg(0, 0, 0, 0); frm = '{8'h01, 8'h80}; extra = 5; run_frame("R7 partial byte dropped");
        cfg(0, 0, 1, 1); frm = '{8'h00, 8'h7E, 8'h13}; run_frame("R2 odd parity");
        cfg(0, 0, 1, 0); frm = '{8'h00, 8'h7E, 8'h13}; run_frame("R2 even parity");
        cfg(0, 0, 1, 1); frm = '{8'h55, 8'hC3}; bad_par = 1; run_frame("R2 bad parity");
        cfg(1, 0, 0, 0); frm = '{8'h93, 8'h20}; add_check(); run_frame("R4 crc16 good");
        cfg(1, 1, 1, 0); frm = '{8'h12, 8'h34, 8'h56}; add_check(); run_frame("R5 crc8 good");
        cfg(1, 0, 0, 0); frm = '{8'h93, 8'h20}; add_check(); frm[3] ^= 8'h10; run_frame("R6 crc16 bad");
        cfg(1, 1, 0, 0); frm = '{8'hDE, 8'hAD}; add_check(); frm[0] ^= 8'h01; run_frame("R6 crc8 bad");
        cfg(1, 0, 0, 0); frm = '{8'h77}; run_frame("R10 short crc16 frame");
        cfg(1, 1, 0, 0); run_frame("R10 empty crc8 frame");
        cfg(0, 0, 0, 0); frm = '{8'h42}; sig_stop = 1; cfg_min_level = 4'd9; run_frame("R8 signal drop");

        // R8: floor of zero never stops; R9 flags cleared after an erroring frame.
        cfg(0, 0, 0, 0); got.delete(); irq_cnt = 0;
        @(negedge clk) rx_sof = 1'b1;
        @(negedge clk) rx_sof = 1'b0;
        send_byte(8'h9C, 0);
        sig_level = 4'd0;
        repeat (5) @(negedge clk);
        chk(rx_active == 1 && irq_cnt == 0, "R8 zero floor keeps receiving", rx_active, 1);
        sig_level = 4'hF;
        rx_eof = 1'b1; @(negedge clk) rx_eof = 1'b0;
        repeat (8) @(negedge clk);
        chk(got.size() == 1 && got[0] == 8'h9C, "R8 zero floor data", got.size(), 1);

        // Seeded random frames.
        for (int t = 0; t < 60; t++) begin
            int n;
            cfg($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
            n = $urandom_range(5);
            for (int i = 0; i < n; i++) frm.push_back(8'($urandom));
            if (cfg_crc_en && $urandom_range(3) != 0) add_check();
            if (frm.size() > 0 && $urandom_range(3) == 0) frm[$urandom_range(frm.size() - 1)] ^= 8'h04;
            if (frm.size() > 0 && $urandom_range(4) == 0) bad_par = $urandom_range(frm.size() - 1);
            extra = $urandom_range(7);
            sig_stop = $urandom_range(1);
            cfg_min_level = 4'($urandom_range(15, 1));
            run_frame("R1 R4 R5 R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule